// File: doc/BRIEF.md
# Nonvolatile Store/Recall Controller

This block is the control state machine for an SRAM that has a nonvolatile shadow copy. It sequences two transfers. A STORE erases the nonvolatile copy and then programs it from the SRAM. A RECALL clears the SRAM and then loads it from the nonvolatile copy. The block issues one command at a time to abstract array movers, waits for each mover's done pulse, and holds the memory disabled until a minimum cycle time, counted in clock cycles, has passed.

A STORE starts in one of two ways. A software trigger starts it unconditionally. A falling edge on the active-low hardware request starts it only when the SRAM is dirty, meaning an accepted write has occurred since the last completed STORE or RECALL. A hardware-started STORE first opens a delay window. During the window the SRAM stays enabled, a write already being strobed may carry on, and new writes are refused. The busy output is a pull-down enable for an externally pulled-up line, so the block can only pull that line low.

A loss of power latches a recall request and disables the memory. When power returns, the latched RECALL runs before any store request is served.

Top module: `nv_shadow_ctrl`

## Requirements
- R1: While reset is held, and afterwards until power is good, chip_dis is 1, wr_inhibit is 1, busy_pulldown is 0 and all four mover commands are 0.
- R2: A RECALL asserts cmd_clear until clear_done, then cmd_load until load_done. cmd_erase and cmd_program stay 0 throughout.
- R3: A falling edge of hw_store_n seen while idle and dirty opens a window of exactly DLY_CYC cycles, with chip_dis 0. cmd_erase follows directly after the window.
- R4: A falling edge of hw_store_n seen while the dirty flag is clear starts no STORE: busy_pulldown and every command stay 0.
- R5: Starting one cycle after the clock edge at which hw_store_n is first sampled low, wr_inhibit is 1 until one cycle after hw_store_n is sampled high again. The exception is a write already strobed at that first edge: it stays accepted while sram_wr is held, up to the end of the delay window.
- R6: A STORE asserts cmd_erase until erase_done, then cmd_program until program_done. busy_pulldown is 1 from the start of the window, or of a software STORE, to the end of the STORE. busy_pulldown is only a pull-down enable: the line reads 1 only through the external pull-up.
- R7: chip_dis stays 1 for exactly STORE_CYC cycles per STORE and RECALL_CYC cycles per RECALL when the movers finish earlier. Writes are accepted again afterwards.
- R8: A write is accepted when sram_wr is 1 and wr_inhibit is 0. Each accepted write sets the dirty flag. A completed STORE or RECALL clears it, so a later hardware request without new writes starts nothing.
- R9: pwr_good low forces chip_dis to 1 on the next cycle, abandons any operation in progress and latches a recall. When pwr_good returns, the RECALL starts even if a software or hardware store is requested at the same time.
- R10: While idle, a sw_recall pulse starts a RECALL and a sw_store pulse starts a STORE regardless of the dirty flag. sw_recall wins over sw_store, and both win over the hardware request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply above the switch threshold |
| hw_store_n | input | 1 | Active-low hardware store request |
| sw_store | input | 1 | One-cycle software STORE trigger |
| sw_recall | input | 1 | One-cycle software RECALL trigger |
| sram_wr | input | 1 | SRAM write strobe, held for the length of a write |
| clear_done | input | 1 | SRAM clear mover finished |
| load_done | input | 1 | Nonvolatile-to-SRAM mover finished |
| erase_done | input | 1 | Nonvolatile erase finished |
| program_done | input | 1 | Nonvolatile program finished |
| busy_pulldown | output | 1 | Pull-down enable for the open-drain busy line |
| wr_inhibit | output | 1 | SRAM writes refused |
| chip_dis | output | 1 | All SRAM access disabled |
| cmd_clear | output | 1 | Command: clear SRAM |
| cmd_load | output | 1 | Command: copy nonvolatile data into SRAM |
| cmd_erase | output | 1 | Command: erase nonvolatile copy |
| cmd_program | output | 1 | Command: program nonvolatile copy from SRAM |

## Verification
The hardest case to reach is a write that is already in flight when the hardware request falls. It must survive the window while an identical strobe one cycle later is refused. The stimulus reaches it by raising sram_wr on one falling clock edge and dropping hw_store_n on the next. That write is accepted before the request edge, so the same sequence also makes the STORE conditional on it. A second hard case is power returning in the same cycle as a software store. It is reached by cutting power in the middle of a STORE and then raising pwr_good together with a sw_store pulse.

// File: rtl/nvsc_pkg.sv
package nvsc_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_IDLE,
        ST_WIN,
        ST_ERASE,
        ST_PROG,
        ST_SFIN,
        ST_CLR,
        ST_LOAD,
        ST_RFIN
    } nvsc_state_e;

endpackage

// File: rtl/nvsc_dirty.sv
module nvsc_dirty (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ok,
    input  logic clr,
    output logic dirty
);
    logic dirty_d, dirty_q;

    always_comb begin
        dirty_d = dirty_q;
        if (clr)   dirty_d = 1'b0;
        if (wr_ok) dirty_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dirty_q <= 1'b0;
        else        dirty_q <= dirty_d;
    end

    assign dirty = dirty_q;

    // R8: an accepted write always leaves the flag set
    a_r8_write_marks_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> dirty);
    // R8: completion without a write leaves the flag clear
    a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wr_ok) |=> !dirty);
endmodule

// File: rtl/nvsc_wr_gate.sv
module nvsc_wr_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_store_n,
    input  logic sram_wr,
    input  logic chip_dis,
    input  logic win_end,
    output logic req_fall,
    output logic wr_inhibit,
    output logic wr_ok
);
    typedef struct packed {
        logic req;
        logic grace;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d     = gate_q;
        gate_d.req = hw_store_n;
        if (req_fall)
            gate_d.grace = sram_wr && !chip_dis;
        else if (!sram_wr || hw_store_n || win_end)
            gate_d.grace = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '{req: 1'b1, grace: 1'b0};
        else        gate_q <= gate_d;
    end

    assign req_fall   = gate_q.req && !hw_store_n;
    assign wr_inhibit = chip_dis || (!gate_q.req && !gate_q.grace);
    assign wr_ok      = sram_wr && !wr_inhibit;

    // R5: a request edge with no write in flight blocks the next cycle
    a_r5_block_new_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fall && !sram_wr) |=> wr_inhibit);
    // R5: a held-low request without grace keeps writes blocked
    a_r5_hold_block: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_q.req && !hw_store_n && !sram_wr) |=> wr_inhibit);
endmodule

// File: rtl/nv_shadow_ctrl.sv
module nv_shadow_ctrl #(
    parameter int DLY_CYC    = 4,
    parameter int STORE_CYC  = 20,
    parameter int RECALL_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic hw_store_n,
    input  logic sw_store,
    input  logic sw_recall,
    input  logic sram_wr,
    input  logic clear_done,
    input  logic load_done,
    input  logic erase_done,
    input  logic program_done,
    output logic busy_pulldown,
    output logic wr_inhibit,
    output logic chip_dis,
    output logic cmd_clear,
    output logic cmd_load,
    output logic cmd_erase,
    output logic cmd_program
);
    import nvsc_pkg::*;

    localparam int TOP_A = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
    localparam int TOP   = (TOP_A > DLY_CYC) ? TOP_A : DLY_CYC;
    localparam int TW    = $clog2(TOP + 1);
    localparam logic [TW-1:0] WIN_LAST = TW'(DLY_CYC - 1);
    localparam logic [TW-1:0] ST_LAST  = TW'(STORE_CYC - 1);
    localparam logic [TW-1:0] RC_LAST  = TW'(RECALL_CYC - 1);
    localparam logic [TW-1:0] T_MAX    = TW'(TOP);

    typedef struct packed {
        nvsc_state_e st;
        logic [TW-1:0] tmr;
        logic          rcl_pend;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [TW-1:0] tmr_inc;
    logic req_fall, wr_ok, dirty, win_end, op_done;

    assign win_end = (ctl_q.st == ST_WIN) && (ctl_q.tmr == WIN_LAST);
    assign op_done = pwr_good &&
        (((ctl_q.st == ST_SFIN) && (ctl_q.tmr >= ST_LAST)) ||
         ((ctl_q.st == ST_RFIN) && (ctl_q.tmr >= RC_LAST)));
    assign tmr_inc = (ctl_q.tmr == T_MAX) ? ctl_q.tmr : ctl_q.tmr + 1'b1;

    always_comb begin
        ctl_d = ctl_q;
        if (!pwr_good) begin
            ctl_d.st       = ST_OFF;
            ctl_d.tmr      = '0;
            ctl_d.rcl_pend = 1'b1;
        end else begin
            unique case (ctl_q.st)
                ST_OFF: if (ctl_q.rcl_pend) begin
                    ctl_d.st       = ST_CLR;
                    ctl_d.tmr      = '0;
                    ctl_d.rcl_pend = 1'b0;
                end
                ST_IDLE: begin
                    ctl_d.tmr = '0;
                    if (sw_recall)              ctl_d.st = ST_CLR;
                    else if (sw_store)          ctl_d.st = ST_ERASE;
                    else if (req_fall && dirty) ctl_d.st = ST_WIN;
                end
                ST_WIN: begin
                    ctl_d.tmr = tmr_inc;
                    if (win_end) begin
                        ctl_d.st  = ST_ERASE;
                        ctl_d.tmr = '0;
                    end
                end
                ST_ERASE: begin
                    ctl_d.tmr = tmr_inc;
                    if (erase_done) ctl_d.st = ST_PROG;
                end
                ST_PROG: begin
                    ctl_d.tmr = tmr_inc;
                    if (program_done) ctl_d.st = ST_SFIN;
                end
                ST_CLR: begin
                    ctl_d.tmr = tmr_inc;
                    if (clear_done) ctl_d.st = ST_LOAD;
                end
                ST_LOAD: begin
                    ctl_d.tmr = tmr_inc;
                    if (load_done) ctl_d.st = ST_RFIN;
                end
                ST_SFIN, ST_RFIN: begin
                    ctl_d.tmr = tmr_inc;
                    if (op_done) begin
                        ctl_d.st  = ST_IDLE;
                        ctl_d.tmr = '0;
                    end
                end
                default: ctl_d.st = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_OFF, tmr: '0, rcl_pend: 1'b1};
        else        ctl_q <= ctl_d;
    end

    assign chip_dis      = !(ctl_q.st inside {ST_IDLE, ST_WIN});
    assign busy_pulldown = ctl_q.st inside {ST_WIN, ST_ERASE, ST_PROG, ST_SFIN};
    assign cmd_clear     = (ctl_q.st == ST_CLR);
    assign cmd_load      = (ctl_q.st == ST_LOAD);
    assign cmd_erase     = (ctl_q.st == ST_ERASE);
    assign cmd_program   = (ctl_q.st == ST_PROG);

    nvsc_wr_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_store_n (hw_store_n),
        .sram_wr    (sram_wr),
        .chip_dis   (chip_dis),
        .win_end    (win_end),
        .req_fall   (req_fall),
        .wr_inhibit (wr_inhibit),
        .wr_ok      (wr_ok)
    );

    nvsc_dirty u_dirty (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_ok (wr_ok),
        .clr   (op_done),
        .dirty (dirty)
    );

    // R2: load only follows clear
    a_r2_load_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_load) |-> $past(cmd_clear));
    // R6: program only follows erase
    a_r6_prog_after_erase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_program) |-> $past(cmd_erase));
    // R6: nonvolatile commands only while the busy line is pulled
    a_r6_busy_in_store: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_erase || cmd_program) |-> busy_pulldown);
    // R4: a clean request edge never raises busy
    a_r4_clean_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && req_fall && !dirty && !sw_store && !sw_recall && pwr_good)
        |=> !busy_pulldown);
    // R9: power loss disables the memory on the next cycle
    a_r9_pwr_loss_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (chip_dis && !busy_pulldown));
    // R7: memory stays disabled while a mover command is active
    a_r7_dis_during_op: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clear || cmd_load || cmd_erase || cmd_program) |-> chip_dis);
endmodule

// File: tb/nv_shadow_ctrl_tb.sv
module nv_shadow_ctrl_tb;
    localparam int DLY = 4;
    localparam int SC  = 20;
    localparam int RC  = 16;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0, hw_store_n = 1'b1, sw_store = 1'b0, sw_recall = 1'b0;
    logic sram_wr = 1'b0;
    logic clear_done = 1'b0, load_done = 1'b0, erase_done = 1'b0, program_done = 1'b0;
    logic busy_pulldown, wr_inhibit, chip_dis, cmd_clear, cmd_load, cmd_erase, cmd_program;
    logic busy_line;

    int errs = 0, checks = 0;
    int mv_cnt = 0;

    always #10 clk = ~clk;

    nv_shadow_ctrl #(.DLY_CYC(DLY), .STORE_CYC(SC), .RECALL_CYC(RC)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .hw_store_n(hw_store_n),
        .sw_store(sw_store), .sw_recall(sw_recall), .sram_wr(sram_wr),
        .clear_done(clear_done), .load_done(load_done), .erase_done(erase_done),
        .program_done(program_done), .busy_pulldown(busy_pulldown),
        .wr_inhibit(wr_inhibit), .chip_dis(chip_dis), .cmd_clear(cmd_clear),
        .cmd_load(cmd_load), .cmd_erase(cmd_erase), .cmd_program(cmd_program));

    // open-drain line with an external pull-up
    assign busy_line = busy_pulldown ? 1'b0 : 1'b1;

    // behavioural reference: phase names as integers
    localparam int P_OFF = 0, P_IDLE = 1, P_WIN = 2, P_ER = 3, P_PG = 4, P_SF = 5,
                   P_CL = 6, P_LD = 7, P_RF = 8;
    int  m_ph = P_OFF, m_el = 0;
    bit  m_pend = 1, m_dirty = 0, m_grace = 0, m_prev = 1;

    function automatic bit m_off(int ph);
        return !(ph == P_IDLE || ph == P_WIN);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = P_OFF; m_el = 0; m_pend = 1; m_dirty = 0; m_grace = 0; m_prev = 1;
        end else begin
            bit inh, ok, fall, wend, fin, ng, nd;
            inh  = m_off(m_ph) || (!m_prev && !m_grace);
            ok   = sram_wr && !inh;
            fall = m_prev && !hw_store_n;
            wend = (m_ph == P_WIN) && (m_el == DLY - 1);
            fin  = pwr_good && ((m_ph == P_SF && m_el >= SC - 1) || (m_ph == P_RF && m_el >= RC - 1));
            ng = m_grace;
            if (fall) ng = sram_wr && !m_off(m_ph);
            else if (!sram_wr || hw_store_n || wend) ng = 0;
            nd = m_dirty;
            if (fin) nd = 0;
            if (ok)  nd = 1;
            if (!pwr_good) begin
                m_ph = P_OFF; m_el = 0; m_pend = 1;
            end else begin
                case (m_ph)
                    P_OFF:  if (m_pend) begin m_ph = P_CL; m_el = 0; m_pend = 0; end
                    P_IDLE: begin
                        m_el = 0;
                        if (sw_recall) m_ph = P_CL;
                        else if (sw_store) m_ph = P_ER;
                        else if (fall && m_dirty) m_ph = P_WIN;
                    end
                    P_WIN:  if (wend) begin m_ph = P_ER; m_el = 0; end else m_el++;
                    P_ER:   begin m_el++; if (erase_done) m_ph = P_PG; end
                    P_PG:   begin m_el++; if (program_done) m_ph = P_SF; end
                    P_CL:   begin m_el++; if (clear_done) m_ph = P_LD; end
                    P_LD:   begin m_el++; if (load_done) m_ph = P_RF; end
                    default: if (fin) begin m_ph = P_IDLE; m_el = 0; end else m_el++;
                endcase
            end
            m_prev = hw_store_n; m_grace = ng; m_dirty = nd;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // trackers
    int n_busy = 0, n_dis = 0, n_winonly = 0, n_erase = 0, n_clear = 0;
    int order_bad = 0, busy_gap = 0, last_cmd = 0;

    task automatic clr_track();
        n_busy = 0; n_dis = 0; n_winonly = 0; n_erase = 0; n_clear = 0;
        order_bad = 0; busy_gap = 0; last_cmd = 0;
    endtask

    task automatic tick();
        bit e_dis, e_busy;
        @(negedge clk);
        e_dis  = m_off(m_ph);
        e_busy = (m_ph >= P_WIN && m_ph <= P_SF);
        chk(chip_dis == e_dis, "R7 chip_dis model", chip_dis, e_dis);
        chk(busy_pulldown == e_busy, "R6 busy model", busy_pulldown, e_busy);
        chk(wr_inhibit == (e_dis || (!m_prev && !m_grace)), "R5 wr_inhibit model",
            wr_inhibit, e_dis || (!m_prev && !m_grace));
        chk({cmd_clear, cmd_load, cmd_erase, cmd_program} ==
            {m_ph == P_CL, m_ph == P_LD, m_ph == P_ER, m_ph == P_PG}, "R2 R6 commands model",
            {cmd_clear, cmd_load, cmd_erase, cmd_program},
            {m_ph == P_CL, m_ph == P_LD, m_ph == P_ER, m_ph == P_PG});
        if (busy_line != !busy_pulldown) chk(0, "R6 busy line", busy_line, !busy_pulldown);
        if (busy_pulldown) n_busy++;
        if (chip_dis) n_dis++;
        if (busy_pulldown && !chip_dis) n_winonly++;
        if (cmd_erase) n_erase++;
        if (cmd_clear) n_clear++;
        if ((cmd_erase || cmd_program) && !busy_pulldown) busy_gap++;
        if (cmd_load && last_cmd != 1 && last_cmd != 2) order_bad++;
        if (cmd_program && last_cmd != 3 && last_cmd != 4) order_bad++;
        if (cmd_clear) last_cmd = 1;
        if (cmd_load) last_cmd = 2;
        if (cmd_erase) last_cmd = 3;
        if (cmd_program) last_cmd = 4;
        // mover stubs
        if (clear_done || load_done || erase_done || program_done) begin
            clear_done = 0; load_done = 0; erase_done = 0; program_done = 0; mv_cnt = 0;
        end else if (cmd_clear || cmd_load || cmd_erase || cmd_program) begin
            if (mv_cnt == LAT - 1) begin
                clear_done = cmd_clear; load_done = cmd_load;
                erase_done = cmd_erase; program_done = cmd_program; mv_cnt = 0;
            end else mv_cnt++;
        end else mv_cnt = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic run_until_free();
        for (int i = 0; i < 200; i++) begin
            tick();
            if (!chip_dis && !busy_pulldown) break;
        end
    endtask

    task automatic do_write();
        sram_wr = 1; tick(); sram_wr = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        ticks(3);
        rst_n = 1;
        tick();
        // R1
        chk(chip_dis && wr_inhibit && !busy_pulldown &&
            !(cmd_clear | cmd_load | cmd_erase | cmd_program), "R1 reset state",
            {chip_dis, wr_inhibit, busy_pulldown}, 3'b110);

        // power-up recall
        clr_track();
        pwr_good = 1;
        tick();
        clr_track();
        chk(cmd_clear, "R9 recall starts on power good", cmd_clear, 1);
        run_until_free();
        chk(n_dis == RC - 1, "R7 recall disable length", n_dis + 1, RC);
        chk(order_bad == 0 && n_erase == 0, "R2 recall order", order_bad + n_erase, 0);

        // clean hardware request
        clr_track();
        hw_store_n = 0;
        ticks(2);
        sram_wr = 1; tick(); sram_wr = 0;
        chk(wr_inhibit, "R5 held request blocks writes", wr_inhibit, 1);
        ticks(15);
        chk(n_busy == 0, "R4 clean request no store", n_busy, 0);
        hw_store_n = 1; ticks(2);

        // dirty hardware request
        do_write();
        clr_track();
        hw_store_n = 0;
        tick();
        chk(wr_inhibit, "R5 new write blocked after edge", wr_inhibit, 1);
        sram_wr = 1;
        for (int i = 0; i < 40 && !cmd_erase; i++) tick();
        sram_wr = 0;
        chk(n_winonly == DLY, "R3 delay window length", n_winonly, DLY);
        n_dis = 0;
        run_until_free();
        chk(n_dis == SC - 1, "R7 store disable length", n_dis + 1, SC);
        chk(order_bad == 0 && busy_gap == 0, "R6 store order and busy", order_bad + busy_gap, 0);
        hw_store_n = 1; ticks(2);
        chk(!wr_inhibit, "R7 writes re-enabled", wr_inhibit, 0);

        // dirty cleared by completion
        clr_track();
        hw_store_n = 0; ticks(12);
        chk(n_busy == 0, "R8 flag cleared after store", n_busy, 0);
        hw_store_n = 1; ticks(2);

        // write in flight at request edge
        sram_wr = 1; tick();
        hw_store_n = 0; tick();
        chk(!wr_inhibit, "R5 grace for write in flight", wr_inhibit, 0);
        tick();
        chk(!wr_inhibit, "R5 grace continues", wr_inhibit, 0);
        sram_wr = 0; tick();
        chk(wr_inhibit, "R5 grace ends with strobe", wr_inhibit, 1);
        clr_track();
        run_until_free();
        chk(n_erase > 0, "R3 in-flight write made store run", n_erase, LAT + 1);
        hw_store_n = 1; ticks(2);

        // software store on a clean array, then software recall
        clr_track();
        sw_store = 1; sw_recall = 0; tick(); sw_store = 0;
        run_until_free();
        chk(n_erase > 0, "R10 software store unconditional", n_erase, LAT + 1);
        clr_track();
        sw_store = 1; sw_recall = 1; tick(); sw_store = 0; sw_recall = 0;
        run_until_free();
        chk(n_clear > 0 && n_erase == 0, "R10 recall wins over store", n_erase, 0);

        // power loss mid-store, recall priority on return
        do_write();
        sw_store = 1; tick(); sw_store = 0;
        ticks(5);
        pwr_good = 0; tick();
        chk(chip_dis && !busy_pulldown, "R9 power loss disables", {chip_dis, busy_pulldown}, 2'b10);
        hw_store_n = 0; ticks(3);
        clr_track();
        pwr_good = 1; sw_store = 1; tick(); sw_store = 0;
        chk(cmd_clear && !cmd_erase, "R9 recall before store", {cmd_clear, cmd_erase}, 2'b10);
        run_until_free();
        chk(n_erase == 0, "R9 no store after return", n_erase, 0);
        hw_store_n = 1; ticks(4);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule